// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block keeps the time of day and the calendar date in packed BCD byte registers. A slow time-base strobe (nominally 32,768 pulses per second, delivered as single-cycle enables in the system clock domain) is divided down to one pulse per second. Each of those pulses advances a carry chain: seconds, minutes, hours, day of week, day of month, month and year. An optional century flag flips when the year wraps. Status and control flags share bytes with the BCD fields: a halt flag lives in the seconds byte and a time-base-failure flag lives in the minutes byte.

A bus agent writes any byte through a simple write strobe. It reads through a combinational read port that shows a visible copy of the registers. While the agent raises the read-hold input, the visible copy is frozen so that a multi-byte read sees one coherent moment. The real count keeps running underneath, and the visible copy catches up once the hold drops. A hold that lasts a quarter of a second or longer stops freezing the copy. Any write to a time byte restarts the sub-second divider, so the written value stays for one full second.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, bytes 0..7 read 0x00, 0x80, 0x00, 0x01, 0x01, 0x01, 0x00, 0x00. The time is 00:00:00, weekday 1, date 01, month 01, year 00, the failure flag (byte 1 bit 7) is 1, and the halt flag (byte 0 bit 7) is 0.
- R2: Seconds (byte 0 bits 6:0, BCD) advance by exactly one for every TICKS_PER_SEC time-base strobes, and never between them.
- R3: The seconds wrap 59 to 00 and carry into the minutes (byte 1 bits 6:0). The minutes wrap 59 to 00 and carry into the hours (byte 2 bits 5:0). The hours wrap 23 to 00 and advance the weekday (byte 3 bits 2:0), which runs 1..7 and wraps 7 to 1, and the date (byte 4 bits 5:0).
- R4: The date wraps to 01 and advances the month (byte 5 bits 4:0) after the month's last day. That day is 30 for months 04, 06, 09 and 11. It is 31 for the other months, except February. February ends on 29 when the BCD year (byte 6) is divisible by 4 and on 28 otherwise.
- R5: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00. On that wrap the century flag (byte 2 bit 6) inverts only when century-enable (byte 2 bit 7) is 1.
- R6: While the halt flag is 1, no second elapses and the failure flag is forced to 1.
- R7: The failure flag keeps its value until byte 1 is written. A write of 0 to it is overridden while the halt flag is 1.
- R8: A write to any of bytes 0..6 restarts the sub-second divider. The next second elapses only after a further TICKS_PER_SEC strobes.
- R9: While read-hold is high and fewer than HOLD_TICKS strobes have passed during the hold, the visible bytes stay frozen. The underlying time keeps counting, and the visible copy shows the advanced time once the hold drops.
- R10: After HOLD_TICKS strobes within one continuous hold, the visible copy follows the live time again, even though the hold is still high.
- R11: Bits that carry no field read as 0: byte 3 bits 7:3, byte 4 bits 7:6 and byte 5 bits 7:5. Byte 7 always reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | Single-cycle strobe of the slow time base |
| wr_en | input | 1 | Write strobe for one register byte |
| wr_addr | input | 3 | Byte index of the write |
| wr_data | input | 8 | Byte value to write |
| rd_hold | input | 1 | High while a read burst is in progress |
| rd_addr | input | 3 | Byte index of the read |
| rd_data | output | 8 | Byte at rd_addr from the visible copy |

## Verification
The checks assume that writes to the time bytes carry legal BCD digits and that TICKS_PER_SEC is at least 2. Under that assumption the seconds stay in range, and a write always blocks a second pulse in the cycle that follows it. The stimulus writes only legal calendar values; the one exception is the unused-bit test, which writes all ones to bytes that do not feed the seconds check and which no second pulse reaches before they are rewritten. The time-base strobes are separated by an idle cycle, and each hold is raised a known number of strobes before a second boundary. This fixes the position of each hold relative to the divider and to the quarter-second limit.

// File: rtl/rtc_cal_pkg.sv
// Shared types and pure functions for the calendar counter chain.
// Assumes fields hold packed BCD; the step function tolerates out-of-range
// values by wrapping when a value reaches or passes its last legal value.
package rtc_cal_pkg;

    localparam int REG_AW = 3;

    // Live or visible register image, one member per field or flag.
    typedef struct packed {
        logic       stop;
        logic       osc_fail;
        logic       cen_en;
        logic       cen_bit;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [2:0] wday;
        logic [5:0] mday;
        logic [4:0] mon;
        logic [7:0] year;
    } cal_state_t;

    // Byte index of each register (the ordering is what a bus agent decodes).
    typedef enum logic [REG_AW-1:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_WDAY  = 3'd3,
        A_MDAY  = 3'd4,
        A_MON   = 3'd5,
        A_YEAR  = 3'd6,
        A_SPARE = 3'd7
    } cal_addr_e;

    localparam cal_state_t CAL_RESET = '{
        stop: 1'b0, osc_fail: 1'b1, cen_en: 1'b0, cen_bit: 1'b0,
        sec: 7'h00, min: 7'h00, hour: 6'h00, wday: 3'd1,
        mday: 6'h01, mon: 5'h01, year: 8'h00
    };

    // One BCD increment: returns {wrapped, next value}.
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        logic [3:0] lo;
        logic [3:0] hi;
        lo = v[3:0];
        hi = v[7:4];
        if (v >= last)
            return {1'b1, first};
        else if (lo >= 4'd9)
            return {1'b0, hi + 4'd1, 4'd0};
        else
            return {1'b0, hi, lo + 4'd1};
    endfunction

    // Last day of a month in BCD, with the every-fourth-year February rule.
    function automatic logic [7:0] month_end(input logic [4:0] mon,
                                             input logic [7:0] year);
        int yb;
        yb = int'(year[7:4]) * 10 + int'(year[3:0]);
        case (mon)
            5'h02:                      return ((yb % 4) == 0) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Assemble the byte seen at one index; bits that carry no field are zero.
    function automatic logic [7:0] pack_reg(input cal_state_t s,
                                            input cal_addr_e a);
        case (a)
            A_SEC:   return {s.stop, s.sec};
            A_MIN:   return {s.osc_fail, s.min};
            A_HOUR:  return {s.cen_en, s.cen_bit, s.hour};
            A_WDAY:  return {5'b0, s.wday};
            A_MDAY:  return {2'b0, s.mday};
            A_MON:   return {3'b0, s.mon};
            A_YEAR:  return s.year;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_sec_divider.sv
// Sub-second divider: counts time-base strobes and emits one single-cycle
// pulse per TICKS_PER_SEC strobes. Assumes osc_tick is already synchronous
// to clk. The count restarts on a time write and is held at zero while halted.
module rtc_sec_divider #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic restart,
    input  logic halt,
    output logic sec_pulse
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    // Pulse on the strobe that completes a second, unless blocked this cycle.
    always_comb begin
        sec_pulse = osc_tick && !halt && !restart && (cnt_q == LAST);
    end

    // Strobe counter with restart and halt clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || halt) begin
            cnt_q <= '0;
        end else if (osc_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_time_regs.sv
// Live timekeeping registers: applies the per-second carry chain and bus
// writes, with a write to a field taking priority over the tick for that
// field. Assumes sec_pulse never coincides with a time write (the divider
// blocks it). The halt flag forces the failure flag on.
module rtc_time_regs
    import rtc_cal_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sec_pulse,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    output cal_state_t              now_q
);
    cal_state_t nxt;
    logic [8:0] st_sec;
    logic [8:0] st_min;
    logic [8:0] st_hour;
    logic [8:0] st_wday;
    logic [8:0] st_mday;
    logic [8:0] st_mon;
    logic [8:0] st_year;

    // Candidate increments of every field, each with its wrap flag.
    always_comb begin
        st_sec  = bcd_step({1'b0, now_q.sec}, 8'h59, 8'h00);
        st_min  = bcd_step({1'b0, now_q.min}, 8'h59, 8'h00);
        st_hour = bcd_step({2'b0, now_q.hour}, 8'h23, 8'h00);
        st_wday = bcd_step({5'b0, now_q.wday}, 8'h07, 8'h01);
        st_mday = bcd_step({2'b0, now_q.mday},
                           month_end(now_q.mon, now_q.year), 8'h01);
        st_mon  = bcd_step({3'b0, now_q.mon}, 8'h12, 8'h01);
        st_year = bcd_step(now_q.year, 8'h99, 8'h00);
    end

    // Next-state: carry chain, then bus write, then failure-flag forcing.
    always_comb begin
        nxt = now_q;
        if (sec_pulse) begin
            nxt.sec = st_sec[6:0];
            if (st_sec[8]) begin
                nxt.min = st_min[6:0];
                if (st_min[8]) begin
                    nxt.hour = st_hour[5:0];
                    if (st_hour[8]) begin
                        nxt.wday = st_wday[2:0];
                        nxt.mday = st_mday[5:0];
                        if (st_mday[8]) begin
                            nxt.mon = st_mon[4:0];
                            if (st_mon[8]) begin
                                nxt.year = st_year[7:0];
                                if (st_year[8] && now_q.cen_en)
                                    nxt.cen_bit = !now_q.cen_bit;
                            end
                        end
                    end
                end
            end
        end
        if (wr_en) begin
            case (cal_addr_e'(wr_addr))
                A_SEC: begin
                    nxt.stop = wr_data[7];
                    nxt.sec  = wr_data[6:0];
                end
                A_MIN: begin
                    nxt.osc_fail = wr_data[7];
                    nxt.min      = wr_data[6:0];
                end
                A_HOUR: begin
                    nxt.cen_en  = wr_data[7];
                    nxt.cen_bit = wr_data[6];
                    nxt.hour    = wr_data[5:0];
                end
                A_WDAY:  nxt.wday = wr_data[2:0];
                A_MDAY:  nxt.mday = wr_data[5:0];
                A_MON:   nxt.mon  = wr_data[4:0];
                A_YEAR:  nxt.year = wr_data;
                default: ;
            endcase
        end
        if (now_q.stop)
            nxt.osc_fail = 1'b1;
    end

    // State register with the power-on image.
    always_ff @(posedge clk) begin
        if (!rst_n)
            now_q <= CAL_RESET;
        else
            now_q <= nxt;
    end

endmodule

// File: rtl/rtc_read_view.sv
// Visible register copy for the read port. It follows the live image one
// cycle behind, freezes while rd_hold is high, and resumes following after
// HOLD_TICKS strobes of one continuous hold. Assumes rd_hold frames a read.
module rtc_read_view
    import rtc_cal_pkg::*;
#(
    parameter int HOLD_TICKS = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                osc_tick,
    input  logic                rd_hold,
    input  cal_state_t          now_st,
    input  logic [REG_AW-1:0]   rd_addr,
    output cal_state_t          vis_q,
    output logic                hold_full,
    output logic [7:0]          rd_data
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_TICKS);

    logic [HW-1:0] hold_cnt_q;

    // Hold window has used up its allowance.
    always_comb begin
        hold_full = (hold_cnt_q == HOLD_MAX);
    end

    // Strobes elapsed within the current hold, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_cnt_q <= '0;
        else if (!rd_hold)
            hold_cnt_q <= '0;
        else if (osc_tick && !hold_full)
            hold_cnt_q <= hold_cnt_q + 1'b1;
    end

    // Visible copy: reload from live time unless a hold is still in force.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vis_q <= CAL_RESET;
        else if (!rd_hold || hold_full)
            vis_q <= now_st;
    end

    // Read multiplexer over the visible copy.
    always_comb begin
        rd_data = pack_reg(vis_q, cal_addr_e'(rd_addr));
    end

endmodule

// File: rtl/rtc_calendar.sv
// Top of the BCD clock-calendar chain: divider, live registers and the
// read view. Assumes all inputs are synchronous to clk; osc_tick is a
// single-cycle strobe at the time-base rate.
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int HOLD_TICKS    = TICKS_PER_SEC / 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_tick,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        rd_hold,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data
);
    logic       sec_pulse;
    logic       wr_time;
    logic       hold_full;
    cal_state_t now_st;
    cal_state_t vis_st;

    // A write to any time byte restarts the sub-second count.
    always_comb begin
        wr_time = wr_en && (cal_addr_e'(wr_addr) != A_SPARE);
    end

    rtc_sec_divider #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .restart  (wr_time),
        .halt     (now_st.stop),
        .sec_pulse(sec_pulse)
    );

    rtc_time_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_pulse(sec_pulse),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .now_q    (now_st)
    );

    rtc_read_view #(
        .HOLD_TICKS(HOLD_TICKS)
    ) view_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .rd_hold  (rd_hold),
        .now_st   (now_st),
        .rd_addr  (rd_addr),
        .vis_q    (vis_st),
        .hold_full(hold_full),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for rtc_calendar, attached by bind. Assumes writes carry
// legal BCD seconds and TICKS_PER_SEC is at least 2.
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       osc_tick,
    input logic       wr_time,
    input logic       rd_hold,
    input logic [2:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       sec_pulse,
    input logic       hold_full,
    input cal_state_t now_st,
    input cal_state_t vis_st
);
    // R2
    pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> osc_tick);

    // R3
    sec_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (now_st.sec[3:0] <= 4'd9) && (now_st.sec[6:4] <= 3'd5));

    // R6
    halt_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        now_st.stop |-> !sec_pulse);

    // R6
    halt_sets_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        now_st.stop |=> now_st.osc_fail);

    // R8
    write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_time |=> !sec_pulse);

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && !hold_full) |=> $stable(vis_st));

    // R10
    view_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hold || hold_full) |=> (vis_st == $past(now_st)));

    // R11
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd7) |-> (rd_data == 8'h00));

endmodule

bind rtc_calendar rtc_calendar_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .wr_time  (wr_time),
    .rd_hold  (rd_hold),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .sec_pulse(sec_pulse),
    .hold_full(hold_full),
    .now_st   (now_st),
    .vis_st   (vis_st)
);

// File: tb/rtc_calendar_tb_top.sv
// Directed bench for rtc_calendar: one task per scenario.
module rtc_calendar_tb_top;

    localparam int TPS  = 16;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_hold = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;

    int total = 0;
    int bad   = 0;

    rtc_calendar #(.TICKS_PER_SEC(TPS), .HOLD_TICKS(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_hold(rd_hold), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        repeat (2) @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic osc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_tick = 1'b1;
            @(negedge clk); osc_tick = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] hr, input logic [7:0] mi,
                            input logic [7:0] se, input logic [7:0] wd,
                            input logic [7:0] md, input logic [7:0] mo,
                            input logic [7:0] yr);
        wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, md); wr(3'd3, wd);
        wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        logic [7:0] exp [8] = '{8'h00, 8'h80, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), d);
            check("R1", $sformatf("reset byte %0d", i), d, exp[i]);
        end
    endtask

    task automatic t_tick;
        logic [7:0] d;
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        osc(TPS - 1);
        rd(3'd0, d); check("R2", "one strobe short of a second", d, 8'h00);
        osc(1);
        rd(3'd0, d); check("R2", "first second", d, 8'h01);
        osc(TPS);
        rd(3'd0, d); check("R2", "second second", d, 8'h02);
    endtask

    task automatic t_carry;
        logic [7:0] d;
        set_time(8'h10, 8'h05, 8'h59, 8'h03, 8'h10, 8'h03, 8'h24);
        osc(TPS);
        rd(3'd1, d); check("R3", "minute carry", d, 8'h06);
        rd(3'd2, d); check("R3", "hour unchanged", d, 8'h10);
        set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h10, 8'h03, 8'h24);
        osc(TPS);
        rd(3'd0, d); check("R3", "midnight seconds", d, 8'h00);
        rd(3'd1, d); check("R3", "midnight minutes", d, 8'h00);
        rd(3'd2, d); check("R3", "midnight hours", d, 8'h00);
        rd(3'd3, d); check("R3", "weekday 7 wraps to 1", d, 8'h01);
        rd(3'd4, d); check("R3", "date advance", d, 8'h11);
    endtask

    task automatic month_case(input logic [7:0] md, input logic [7:0] mo,
                              input logic [7:0] yr, input logic [7:0] emd,
                              input logic [7:0] emo, input string what);
        logic [7:0] d;
        set_time(8'h23, 8'h59, 8'h59, 8'h02, md, mo, yr);
        osc(TPS);
        rd(3'd4, d); check("R4", {what, " date"}, d, emd);
        rd(3'd5, d); check("R4", {what, " month"}, d, emo);
    endtask

    task automatic t_months;
        month_case(8'h30, 8'h04, 8'h23, 8'h01, 8'h05, "30-day month end");
        month_case(8'h30, 8'h01, 8'h23, 8'h31, 8'h01, "31-day month day 30");
        month_case(8'h31, 8'h01, 8'h23, 8'h01, 8'h02, "31-day month end");
        month_case(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "Feb common year");
        month_case(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "Feb leap day 28");
        month_case(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "Feb leap end");
    endtask

    task automatic t_year;
        logic [7:0] d;
        set_time(8'hA3, 8'h59, 8'h59, 8'h04, 8'h31, 8'h12, 8'h99);
        osc(TPS);
        rd(3'd6, d); check("R5", "year wraps", d, 8'h00);
        rd(3'd5, d); check("R5", "month wraps", d, 8'h01);
        rd(3'd4, d); check("R5", "date wraps", d, 8'h01);
        rd(3'd2, d); check("R5", "century flips when enabled", d, 8'hC0);
        set_time(8'h63, 8'h59, 8'h59, 8'h04, 8'h31, 8'h12, 8'h99);
        osc(TPS);
        rd(3'd2, d); check("R5", "century held when disabled", d, 8'h40);
    endtask

    task automatic t_stop;
        logic [7:0] d;
        wr(3'd1, 8'h07);
        rd(3'd1, d); check("R7", "failure flag cleared by write", d, 8'h07);
        wr(3'd0, 8'h92);
        osc(3 * TPS);
        rd(3'd0, d); check("R6", "halted seconds frozen", d, 8'h92);
        rd(3'd1, d); check("R6", "halt sets failure flag", d, 8'h87);
        wr(3'd1, 8'h07);
        rd(3'd1, d); check("R7", "clear ignored while halted", d, 8'h87);
        wr(3'd0, 8'h12);
        wr(3'd1, 8'h07);
        rd(3'd1, d); check("R7", "clear after restart", d, 8'h07);
        osc(TPS);
        rd(3'd1, d); check("R7", "flag stays clear while running", d, 8'h07);
        rd(3'd0, d); check("R6", "counting resumes", d, 8'h13);
    endtask

    task automatic t_restart;
        logic [7:0] d;
        wr(3'd0, 8'h20);
        osc(10);
        wr(3'd0, 8'h30);
        osc(TPS - 1);
        rd(3'd0, d); check("R8", "write restarts divider", d, 8'h30);
        osc(1);
        rd(3'd0, d); check("R8", "full second after write", d, 8'h31);
    endtask

    task automatic t_hold;
        logic [7:0] d;
        wr(3'd0, 8'h40);
        osc(TPS - 1);
        @(negedge clk); rd_hold = 1'b1;
        osc(1);
        rd(3'd0, d); check("R9", "view frozen in hold", d, 8'h40);
        @(negedge clk); rd_hold = 1'b0;
        rd(3'd0, d); check("R9", "pending second shown after hold", d, 8'h41);
        osc(TPS);
        rd(3'd0, d); check("R9", "no time lost", d, 8'h42);
    endtask

    task automatic t_hold_limit;
        logic [7:0] d;
        wr(3'd0, 8'h50);
        osc(TPS - 1);
        @(negedge clk); rd_hold = 1'b1;
        osc(1);
        rd(3'd0, d); check("R10", "frozen before limit", d, 8'h50);
        osc(HOLD - 1);
        rd(3'd0, d); check("R10", "view follows after limit", d, 8'h51);
        @(negedge clk); rd_hold = 1'b0;
    endtask

    task automatic t_unused;
        logic [7:0] d;
        wr(3'd3, 8'hFF);
        rd(3'd3, d); check("R11", "weekday spare bits", d, 8'h07);
        wr(3'd4, 8'hFF);
        rd(3'd4, d); check("R11", "date spare bits", d, 8'h3F);
        wr(3'd5, 8'hE9);
        rd(3'd5, d); check("R11", "month spare bits", d, 8'h09);
        wr(3'd7, 8'hFF);
        rd(3'd7, d); check("R11", "byte 7 ignores write", d, 8'h00);
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tick();
        t_carry();
        t_months();
        t_year();
        t_stop();
        t_restart();
        t_hold();
        t_hold_limit();
        t_unused();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule